// File: doc/BRIEF.md
# Flash Write-Status Output Generator

This block is the device-side read path of a NOR-style flash model while an embedded program or erase is under way. A host that has issued the last write of a program or erase command keeps reading the part. Bit 7 of each read tells it whether the operation is still running. During a program, bit 7 is the inverse of the programmed bit 7 until the write finishes. During an erase, bit 7 is held at 0 until the erase ends or the erase is suspended. An active-low ready/busy pin shows the same state in hardware.

Every operation length is a cycle count set by a parameter. This covers normal programs and erases, and also the short windows in which a program aimed at a protected sector, or an erase whose selected sectors are all protected, shows status and then drops back to read mode with nothing changed. An erase can be suspended. While it is suspended, other sectors can be read or programmed, and the erase can then be resumed with its remaining time intact. When a program or erase completes normally, the first read returns the true bit 7 while bits 6..0 are still invalid. The read after that returns array data.

The cell array, the command decoder, the toggle bits and the bit-5 time-out are outside this block. The bench or the surrounding model supplies the array read value.

Top module: `flash_wstat`

## Requirements
- R1: While reset is held and after it is released, the bank is in read mode: `ry_by_n` is 1 and `dq` equals `array_rd` whenever `oe` is 1.
- R2: A program command is a `start` pulse with `op`=2'b01 issued in read mode. If its sector is unprotected, the bank is busy (`ry_by_n`=0) for exactly PROG_CYC clock edges starting with the edge that accepts the command. During that time `dq` reads {~prog_data[7], 7'b0}.
- R3: When a normal program or erase finishes, `ry_by_n` returns to 1 and a completion state holds until the first clock edge with `oe`=1. In that state `dq` is {prog_data[7], ~prog_data[6:0]} after a program and 8'h80 after an erase. Reads after that edge return `array_rd`.
- R4: A sector erase (`op`=2'b10, sectors chosen by `erase_sel`) or a chip erase (`op`=2'b11, all sectors) with at least one unprotected target keeps the bank busy for ERASE_CYC active edges. During that time `dq` reads 8'h00.
- R5: A program whose sector has its `prot_map` bit set is busy for PROT_PROG_CYC edges with the same inverted bit-7 status. The bank then goes straight to read mode, with no completion state.
- R6: An erase whose targets are all protected is busy for PROT_ERASE_CYC edges with `dq` at 8'h00. The bank then goes straight to read mode.
- R7: In a partly protected erase, only the selected unprotected sectors are erased. While the erase is suspended, a read in a protected selected sector returns `array_rd`.
- R8: A `susp_req` pulse during a running erase puts the bank in suspend. In suspend, `ry_by_n` is 1, reads in sectors being erased return 8'h80, and other sectors return `array_rd`. The erase timer is frozen. After a `resume_req` pulse, the erase runs for exactly its remaining edges.
- R9: A program issued in suspend is busy for PROG_CYC edges (PROT_PROG_CYC if its sector is protected) with `dq` = {~prog_data[7], 7'b0}. The bank then returns to suspend, not to read mode.
- R10: `start`, `susp_req` and `resume_req` are ignored while a program or protected window is running. `susp_req` is ignored outside a running erase.
- R11: While `oe` is 0, `dq` is 8'h00 in every state.

Sector index fields (`prog_sect`, `rd_sect`) are the upper address bits. Bit *n* of `erase_sel` and of `prot_map` refers to sector *n*.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse: final write strobe of a command |
| op | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 none |
| prog_sect | input | SECT_W | Sector field of the program address |
| prog_data | input | 8 | Datum being programmed |
| erase_sel | input | NUM_SECT | Sectors chosen for a sector erase |
| prot_map | input | NUM_SECT | Per-sector protection flags |
| susp_req | input | 1 | Erase-suspend pulse |
| resume_req | input | 1 | Erase-resume pulse |
| rd_sect | input | SECT_W | Sector field of the read address |
| oe | input | 1 | Output enable; a high sample is one read |
| array_rd | input | 8 | Array read value for the current read address |
| dq | output | 8 | Read bus |
| ry_by_n | output | 1 | Ready (1) / busy (0) |

## Verification
On every cycle, assertions check several rules. Bit 7 is 0 during a running erase. The pin reports busy during a program. Suspend reports ready. The bus is quiet with `oe` low. The completion state lasts one read. A protected window exits only to read mode. A suspended program returns only to suspend. A running program cannot be replaced, and its timer never wraps. The bench's directed scenarios show the rest: the exact busy lengths for each operation kind, that a suspended erase keeps its remaining time, which sectors return status in suspend, and the two-step completion read.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_PROG   = 2'b01,
    OP_SERASE = 2'b10,
    OP_CERASE = 2'b11
  } wsg_op_e;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROT  = 3'd3,
    ST_SUSP  = 3'd4,
    ST_SPROG = 3'd5,
    ST_FIN   = 3'd6
  } wsg_state_e;
endpackage

// File: rtl/wsg_rst_sync.sv
module wsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/wsg_timer.sv
module wsg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q == CNT_W'(1));

  AST_TIMER_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/wsg_sector_map.sv
module wsg_sector_map #(
  parameter int NUM_SECT = 4,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic [SECT_W-1:0]   prog_sect,
  input  logic [NUM_SECT-1:0] erase_sel,
  input  logic [NUM_SECT-1:0] prot_map,
  input  logic                whole_chip,
  output logic [NUM_SECT-1:0] erase_mask,
  output logic                all_prot,
  output logic                prog_prot
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign erase_mask[s] = (whole_chip | erase_sel[s]) & ~prot_map[s];
  end

  assign all_prot  = (erase_mask == '0);
  assign prog_prot = prot_map[prog_sect];
endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
#(
  parameter int CNT_W          = 8,
  parameter int NUM_SECT       = 4,
  parameter int PROG_CYC       = 6,
  parameter int ERASE_CYC      = 20,
  parameter int PROT_PROG_CYC  = 3,
  parameter int PROT_ERASE_CYC = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  wsg_op_e             op,
  input  logic [7:0]          prog_data,
  input  logic                prog_prot,
  input  logic [NUM_SECT-1:0] erase_mask,
  input  logic                all_prot,
  input  logic                susp_req,
  input  logic                resume_req,
  input  logic                oe,
  input  logic                exp_main,
  input  logic                exp_sp,
  output wsg_state_e          state,
  output logic [7:0]          lat_data,
  output logic                lat_prog,
  output logic [NUM_SECT-1:0] lat_mask,
  output logic                ld_main,
  output logic [CNT_W-1:0]    ld_main_val,
  output logic                run_main,
  output logic                ld_sp,
  output logic [CNT_W-1:0]    ld_sp_val,
  output logic                run_sp
);
  wsg_state_e state_d;
  logic       cap_data, cap_mask, lat_prog_d;

  always_comb begin
    state_d     = state;
    cap_data    = 1'b0;
    cap_mask    = 1'b0;
    lat_prog_d  = lat_prog;
    ld_main     = 1'b0;
    ld_main_val = '0;
    ld_sp       = 1'b0;
    ld_sp_val   = '0;
    case (state)
      ST_READ, ST_FIN: begin
        if (state == ST_FIN && oe) state_d = ST_READ;
        if (start && op == OP_PROG) begin
          cap_data   = 1'b1;
          lat_prog_d = 1'b1;
          ld_main    = 1'b1;
          if (prog_prot) begin
            state_d     = ST_PROT;
            ld_main_val = CNT_W'(PROT_PROG_CYC);
          end else begin
            state_d     = ST_PROG;
            ld_main_val = CNT_W'(PROG_CYC);
          end
        end else if (start && op != OP_NONE) begin
          cap_mask   = 1'b1;
          lat_prog_d = 1'b0;
          ld_main    = 1'b1;
          if (all_prot) begin
            state_d     = ST_PROT;
            ld_main_val = CNT_W'(PROT_ERASE_CYC);
          end else begin
            state_d     = ST_ERASE;
            ld_main_val = CNT_W'(ERASE_CYC);
          end
        end
      end
      ST_PROG:  if (exp_main) state_d = ST_FIN;
      ST_PROT:  if (exp_main) state_d = ST_READ;
      ST_ERASE: begin
        if (exp_main) state_d = ST_FIN;
        else if (susp_req) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (start && op == OP_PROG) begin
          cap_data  = 1'b1;
          ld_sp     = 1'b1;
          ld_sp_val = prog_prot ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
          state_d   = ST_SPROG;
        end else if (resume_req) begin
          state_d = ST_ERASE;
        end
      end
      ST_SPROG: if (exp_sp) state_d = ST_SUSP;
      default:  state_d = ST_READ;
    endcase
  end

  assign run_main = (state == ST_PROG) | (state == ST_ERASE) | (state == ST_PROT);
  assign run_sp   = (state == ST_SPROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      lat_prog <= 1'b0;
    end else begin
      state    <= state_d;
      lat_prog <= lat_prog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_data <= '0;
    else if (cap_data) lat_data <= prog_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_mask <= '0;
    else if (cap_mask) lat_mask <= erase_mask;
  end

  AST_FIN_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && oe && !start) |=> (state == ST_READ)); // R3
  AST_PROT_EXITS_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROT) |=> (state == ST_PROT || state == ST_READ)); // R5
  AST_SPROG_BACK_TO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPROG) |=> (state == ST_SPROG || state == ST_SUSP)); // R9
  AST_PROG_NOT_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && !exp_main) |=> (state == ST_PROG && $stable(lat_data))); // R10
endmodule

// File: rtl/wsg_dout.sv
module wsg_dout
  import wsg_pkg::*;
(
  input  wsg_state_e state,
  input  logic [7:0] lat_data,
  input  logic       lat_prog,
  input  logic       rd_in_erase,
  input  logic       oe,
  input  logic [7:0] array_rd,
  output logic [7:0] dq,
  output logic       ry_by_n
);
  logic [7:0] rd_val;
  logic [7:0] prog_stat;

  assign prog_stat = {~lat_data[7], 7'b0};

  always_comb begin
    rd_val  = array_rd;
    ry_by_n = 1'b1;
    case (state)
      ST_PROG, ST_SPROG: begin
        ry_by_n = 1'b0;
        rd_val  = prog_stat;
      end
      ST_PROT: begin
        ry_by_n = 1'b0;
        rd_val  = lat_prog ? prog_stat : 8'h00;
      end
      ST_ERASE: begin
        ry_by_n = 1'b0;
        rd_val  = 8'h00;
      end
      ST_SUSP: rd_val = rd_in_erase ? 8'h80 : array_rd;
      ST_FIN:  rd_val = lat_prog ? {lat_data[7], ~lat_data[6:0]} : 8'h80;
      default: rd_val = array_rd;
    endcase
  end

  assign dq = oe ? rd_val : 8'h00;
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import wsg_pkg::*;
#(
  parameter int NUM_SECT       = 4,
  parameter int PROG_CYC       = 300,
  parameter int ERASE_CYC      = 20000,
  parameter int PROT_PROG_CYC  = 50,
  parameter int PROT_ERASE_CYC = 5000,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int MAX_B   = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC,
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [SECT_W-1:0]   prog_sect,
  input  logic [7:0]          prog_data,
  input  logic [NUM_SECT-1:0] erase_sel,
  input  logic [NUM_SECT-1:0] prot_map,
  input  logic                susp_req,
  input  logic                resume_req,
  input  logic [SECT_W-1:0]   rd_sect,
  input  logic                oe,
  input  logic [7:0]          array_rd,
  output logic [7:0]          dq,
  output logic                ry_by_n
);
  logic                rst_i_n;
  wsg_op_e             op_e;
  wsg_state_e          state;
  logic [NUM_SECT-1:0] erase_mask, lat_mask;
  logic                all_prot, prog_prot;
  logic [7:0]          lat_data;
  logic                lat_prog;
  logic                ld_main, run_main, exp_main;
  logic                ld_sp, run_sp, exp_sp;
  logic [CNT_W-1:0]    ld_main_val, ld_sp_val;
  logic                rd_in_erase;

  assign op_e        = wsg_op_e'(op);
  assign rd_in_erase = lat_mask[rd_sect];

  wsg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wsg_sector_map #(.NUM_SECT(NUM_SECT)) u_map (
    .prog_sect  (prog_sect),
    .erase_sel  (erase_sel),
    .prot_map   (prot_map),
    .whole_chip (op_e == OP_CERASE),
    .erase_mask (erase_mask),
    .all_prot   (all_prot),
    .prog_prot  (prog_prot)
  );

  wsg_ctrl #(
    .CNT_W          (CNT_W),
    .NUM_SECT       (NUM_SECT),
    .PROG_CYC       (PROG_CYC),
    .ERASE_CYC      (ERASE_CYC),
    .PROT_PROG_CYC  (PROT_PROG_CYC),
    .PROT_ERASE_CYC (PROT_ERASE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .start       (start),
    .op          (op_e),
    .prog_data   (prog_data),
    .prog_prot   (prog_prot),
    .erase_mask  (erase_mask),
    .all_prot    (all_prot),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .oe          (oe),
    .exp_main    (exp_main),
    .exp_sp      (exp_sp),
    .state       (state),
    .lat_data    (lat_data),
    .lat_prog    (lat_prog),
    .lat_mask    (lat_mask),
    .ld_main     (ld_main),
    .ld_main_val (ld_main_val),
    .run_main    (run_main),
    .ld_sp       (ld_sp),
    .ld_sp_val   (ld_sp_val),
    .run_sp      (run_sp)
  );

  wsg_timer #(.CNT_W(CNT_W)) u_tmr_main (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (ld_main),
    .load_val (ld_main_val),
    .run      (run_main),
    .expire   (exp_main)
  );

  wsg_timer #(.CNT_W(CNT_W)) u_tmr_susp (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (ld_sp),
    .load_val (ld_sp_val),
    .run      (run_sp),
    .expire   (exp_sp)
  );

  wsg_dout u_dout (
    .state       (state),
    .lat_data    (lat_data),
    .lat_prog    (lat_prog),
    .rd_in_erase (rd_in_erase),
    .oe          (oe),
    .array_rd    (array_rd),
    .dq          (dq),
    .ry_by_n     (ry_by_n)
  );

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    !oe |-> (dq == 8'h00)); // R11
  AST_ERASE_B7_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == ST_ERASE) |-> !dq[7]); // R4
  AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == ST_SUSP) |-> ry_by_n); // R8
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run_main || run_sp) |-> !ry_by_n); // R2
endmodule

// File: tb/sim_flash_wstat.sv
`timescale 1ns/1ps
module sim_flash_wstat;
  localparam int NS  = 4;
  localparam int PC  = 6;
  localparam int EC  = 20;
  localparam int PPC = 3;
  localparam int PEC = 12;
  localparam logic [7:0] ARR = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, susp_req, resume_req, oe;
  logic [1:0]    op;
  logic [1:0]    prog_sect, rd_sect;
  logic [7:0]    prog_data, array_rd, dq;
  logic [NS-1:0] erase_sel, prot_map;
  logic          ry_by_n;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  flash_wstat #(
    .NUM_SECT(NS), .PROG_CYC(PC), .ERASE_CYC(EC),
    .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .prog_sect(prog_sect),
    .prog_data(prog_data), .erase_sel(erase_sel), .prot_map(prot_map),
    .susp_req(susp_req), .resume_req(resume_req), .rd_sect(rd_sect), .oe(oe),
    .array_rd(array_rd), .dq(dq), .ry_by_n(ry_by_n)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dq act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ry_by_n act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Issue a command; returns one ns after the negedge that follows the accepting edge.
  task automatic cmd(input logic [1:0] o, input logic [1:0] sect,
                     input logic [7:0] d, input logic [NS-1:0] sel);
    @(negedge clk);
    start = 1'b1; op = o; prog_sect = sect; prog_data = d; erase_sel = sel;
    @(negedge clk);
    start = 1'b0; op = 2'b00;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 0; op = 0; prog_sect = 0; prog_data = 0;
    erase_sel = 0; prot_map = 0; susp_req = 0; resume_req = 0;
    rd_sect = 0; oe = 1'b1; array_rd = ARR;
    step(3);
    chk1("R1 ready in reset", ry_by_n, 1'b1);
    chk8("R1 array in reset", dq, ARR);
    @(negedge clk) rst_n = 1'b1;
    step(3);
    chk1("R1 ready after reset", ry_by_n, 1'b1);
    chk8("R1 array after reset", dq, ARR);
  endtask

  task automatic t_prog(input logic [7:0] d);
    cmd(2'b01, 2'd0, d, '0);
    chk1("R2 busy first", ry_by_n, 1'b0);
    chk8("R2 inverse b7 first", dq, {~d[7], 7'b0});
    step(PC - 1);
    chk1("R2 busy last", ry_by_n, 1'b0);
    chk8("R2 inverse b7 last", dq, {~d[7], 7'b0});
    step(1);
    chk1("R3 ready at finish", ry_by_n, 1'b1);
    chk8("R3 true b7 first read", dq, {d[7], ~d[6:0]});
    step(1);
    chk8("R3 array next read", dq, ARR);
  endtask

  task automatic t_chip_erase;
    cmd(2'b11, 2'd0, 8'h00, '0);
    chk1("R4 busy first", ry_by_n, 1'b0);
    chk8("R4 zero first", dq, 8'h00);
    step(EC - 1);
    chk1("R4 busy last", ry_by_n, 1'b0);
    chk8("R4 zero last", dq, 8'h00);
    step(1);
    chk1("R3 ready after erase", ry_by_n, 1'b1);
    chk8("R3 erase done b7", dq, 8'h80);
    step(1);
    chk8("R3 array after erase", dq, ARR);
  endtask

  task automatic t_prot_prog;
    prot_map = 4'b0100;
    cmd(2'b01, 2'd2, 8'h43, '0);
    chk1("R5 busy first", ry_by_n, 1'b0);
    chk8("R5 status first", dq, 8'h80);
    step(PPC - 1);
    chk1("R5 busy last", ry_by_n, 1'b0);
    step(1);
    chk1("R5 ready", ry_by_n, 1'b1);
    chk8("R5 straight to read", dq, ARR);
    prot_map = '0;
  endtask

  task automatic t_prot_erase;
    prot_map = 4'b0100;
    cmd(2'b10, 2'd0, 8'h00, 4'b0100);
    chk1("R6 busy first", ry_by_n, 1'b0);
    chk8("R6 zero first", dq, 8'h00);
    step(PEC - 1);
    chk1("R6 busy last", ry_by_n, 1'b0);
    step(1);
    chk1("R6 ready", ry_by_n, 1'b1);
    chk8("R6 straight to read", dq, ARR);
    prot_map = '0;
  endtask

  task automatic t_suspend;
    int rem;
    prot_map = 4'b0010;
    cmd(2'b10, 2'd0, 8'h00, 4'b0011);
    step(3);
    susp_req = 1'b1;
    @(negedge clk) susp_req = 1'b0;
    #1;
    rem = EC - 4;
    chk1("R8 ready in suspend", ry_by_n, 1'b1);
    rd_sect = 2'd0; #1;
    chk8("R8 erasing sector status", dq, 8'h80);
    rd_sect = 2'd1; #1;
    chk8("R7 protected sector skipped", dq, ARR);
    rd_sect = 2'd3; #1;
    chk8("R8 other sector array", dq, ARR);
    step(5);
    rd_sect = 2'd0; #1;
    chk8("R8 still suspended", dq, 8'h80);
    cmd(2'b01, 2'd3, 8'h11, '0);
    chk1("R9 busy", ry_by_n, 1'b0);
    chk8("R9 inverse b7", dq, 8'h80);
    step(PC - 1);
    chk1("R9 busy last", ry_by_n, 1'b0);
    step(1);
    chk1("R9 ready again", ry_by_n, 1'b1);
    chk8("R9 back in suspend", dq, 8'h80);
    resume_req = 1'b1;
    @(negedge clk) resume_req = 1'b0;
    #1;
    chk1("R8 busy after resume", ry_by_n, 1'b0);
    chk8("R8 zero after resume", dq, 8'h00);
    step(rem - 1);
    chk1("R8 remaining kept", ry_by_n, 1'b0);
    step(1);
    chk1("R8 done after remaining", ry_by_n, 1'b1);
    chk8("R3 erase done after resume", dq, 8'h80);
    step(1);
    prot_map = '0;
  endtask

  task automatic t_ignore;
    cmd(2'b01, 2'd0, 8'h43, '0);
    step(1);
    @(negedge clk);
    start = 1'b1; op = 2'b11;
    @(negedge clk);
    start = 1'b0; op = 2'b00; susp_req = 1'b1;
    @(negedge clk);
    susp_req = 1'b0;
    #1;
    step(PC - 5);
    chk1("R10 still busy", ry_by_n, 1'b0);
    chk8("R10 program status kept", dq, 8'h80);
    step(1);
    chk8("R10 program result not erase", dq, 8'h3C);
    step(1);
    susp_req = 1'b1;
    @(negedge clk) susp_req = 1'b0;
    #1;
    chk1("R10 suspend ignored in read", ry_by_n, 1'b1);
    chk8("R10 read after ignored suspend", dq, ARR);
  endtask

  task automatic t_oe;
    oe = 1'b0;
    #1;
    chk8("R11 quiet in read", dq, 8'h00);
    cmd(2'b01, 2'd0, 8'hC3, '0);
    chk8("R11 quiet while busy", dq, 8'h00);
    step(PC + 3);
    chk1("R3 ready with no read", ry_by_n, 1'b1);
    chk8("R11 quiet after finish", dq, 8'h00);
    oe = 1'b1;
    #1;
    chk8("R3 completion held until read", dq, 8'hBC);
    step(1);
    chk8("R3 array after held read", dq, ARR);
  endtask

  initial begin
    t_reset();
    t_prog(8'h43);
    t_prog(8'hC3);
    t_chip_erase();
    t_prot_prog();
    t_prot_erase();
    t_suspend();
    t_ignore();
    t_oe();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule